// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator and Tap Modulator

This block closes the loop around an on-chip digitally controlled oscillator (DCO) so that its frequency tracks a chosen multiple of a slow reference clock. The block runs in the DCO clock domain. It synchronizes the reference, counts how many DCO cycles fit into each reference period, and compares that count with a target. On every reference period it moves a 10-bit frequency integrator one step up or down. The integrator's upper five bits pick a coarse oscillator tap. Its lower five bits set how many cycles in each 32-cycle frame borrow the next faster tap, which gives fractional frequency steps between taps.

The oscillator cell takes the tap number and the per-cycle "use tap+1" flag from this block. The block also produces the clock seen by the rest of the system. That clock is either the raw DCO clock or the DCO clock divided by a selectable power of two. Software may freeze the loop and load the integrator directly. Writing zero restarts the search from the lowest tap.

Top module: `fll_core`

## Requirements
- R1: The target count is D×(mult_n+1), where D = 2^div_code (div_code 0,1,2,3 gives D = 1,2,4,8). At each synchronized rising edge of ref_clk, the number of dco_clk cycles since the previous such edge is compared with the target. A count below the target steps the integrator by +1. A count equal to or above the target steps it by −1.
- R2: Outside a direct load, integ_q changes only after a reference edge, and then by exactly one.
- R3: The integrator saturates. A +1 step at 1023 leaves it at 1023, and a −1 step at 0 leaves it at 0.
- R4: While loop_hold is 1, reference edges do not change integ_q.
- R5: A cycle with integ_wr = 1 loads integ_wdata into the integrator. The new value is visible on integ_q after the next dco_clk edge, whether or not loop_hold is set.
- R6: tap_sel equals integ_q[9:5] limited to 28, so raw values 28 to 31 all give 28. It is refreshed once per 32-cycle frame.
- R7: With a steady integrator below the tap limit, any 32 consecutive dco_clk cycles contain exactly M cycles with tap_up = 1, where M = integ_q[4:0].
- R8: The tap_up cycles are spread by accumulate-and-carry. For M ≤ 16, tap_up is never high in two consecutive cycles.
- R9: When the raw tap integ_q[9:5] is 28 or more, tap_up stays 0.
- R10: With range_ext = 0, clk_out is dco_clk divided by D with equal high and low times. With range_ext = 1, clk_out is dco_clk itself.
- R11: After reset, integ_q, tap_sel and tap_up are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_clk | input | 1 | Raw oscillator clock; clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to dco_clk |
| mult_n | input | 7 | Frequency multiplier N |
| range_ext | input | 1 | 1: clk_out is the undivided DCO clock |
| div_code | input | 2 | Post-divider select, D = 2^div_code |
| loop_hold | input | 1 | 1: integrator ignores reference edges |
| integ_wr | input | 1 | Load strobe for the integrator |
| integ_wdata | input | 10 | Value loaded on integ_wr |
| tap_sel | output | 5 | Oscillator tap, 0 to 28 |
| tap_up | output | 1 | This cycle uses tap_sel+1 |
| clk_out | output | 1 | System clock after optional division |
| integ_q | output | 10 | Current integrator value |

## Verification
The assertions check these properties on every cycle:
- the integrator moves by at most one step, and only after a reference event;
- it stays frozen while held;
- it never wraps at either end;
- a load lands exactly;
- the tap stays within range;
- no tap+1 cycle appears at the top tap;
- each completed frame carries exactly the latched modulation count.

The step direction, the equal-count boundary and the divided clock rate can only be shown by the bench's scenarios. These depend on how the reference period relates to N and D, and that relation exists only in the stimulus.

// File: rtl/fll_pkg.sv
package fll_pkg;

  // Number of raw DCO cycles expected in one reference period.
  function automatic logic [11:0] fll_target(input logic [6:0] n, input logic [1:0] code);
    logic [11:0] base;
    base = {5'd0, n} + 12'd1;
    return base << code;
  endfunction

  // Limit a raw tap to the highest usable position.
  function automatic logic [4:0] fll_tap_clamp(input logic [4:0] raw, input logic [4:0] lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // Saturating one-step move of the integrator.
  function automatic logic [9:0] fll_step(input logic [9:0] cur, input logic up, input logic dn);
    logic [9:0] res;
    res = cur;
    if (up && cur != 10'h3FF) res = cur + 10'd1;
    else if (dn && cur != 10'h000) res = cur - 10'd1;
    return res;
  endfunction

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_evt
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[DEPTH-2:0], ref_in};
  end

  // Rising edge of the synchronized reference, one cycle wide.
  assign ref_evt = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fll_integrator.sv
module fll_integrator
  import fll_pkg::*;
#(
  parameter int INTEG_W = 10,
  parameter int MULT_W  = 7,
  parameter int CODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_evt,
  input  logic [MULT_W-1:0]  mult_n,
  input  logic [CODE_W-1:0]  div_code,
  input  logic               hold,
  input  logic               wr,
  input  logic [INTEG_W-1:0] wdata,
  output logic [INTEG_W-1:0] integ,
  output logic               step_up,
  output logic               step_dn
);
  localparam int CNT_W = MULT_W + 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W-1:0] target;

  always_comb target = CNT_W'(fll_target(mult_n, div_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_cnt <= '0;
    else if (ref_evt)        cyc_cnt <= CNT_W'(1);
    else if (cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + CNT_W'(1);
  end

  assign step_up = ref_evt && !hold && (cyc_cnt <  target);
  assign step_dn = ref_evt && !hold && (cyc_cnt >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  integ <= '0;
    else if (wr) integ <= wdata;
    else         integ <= fll_step(integ, step_up, step_dn);
  end
endmodule

// File: rtl/fll_modulator.sv
module fll_modulator
  import fll_pkg::*;
#(
  parameter int INTEG_W   = 10,
  parameter int MOD_W     = 5,
  parameter int TAP_LIMIT = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INTEG_W-1:0] integ,
  output logic [INTEG_W-MOD_W-1:0] tap_sel,
  output logic               tap_up,
  output logic               frame_last,
  output logic [MOD_W-1:0]   m_frame
);
  localparam int TAP_W = INTEG_W - MOD_W;
  localparam logic [TAP_W-1:0] LIM = TAP_W'(TAP_LIMIT);

  logic [MOD_W-1:0] phase;
  logic [MOD_W-1:0] acc;
  logic [TAP_W-1:0] tap_raw;
  logic [MOD_W-1:0] m_next;
  logic [MOD_W:0]   sum;

  assign tap_raw    = integ[INTEG_W-1:MOD_W];
  assign m_next     = (tap_raw >= LIM) ? '0 : integ[MOD_W-1:0];
  assign frame_last = (phase == '1);
  assign sum        = {1'b0, acc} + {1'b0, m_frame};
  assign tap_up     = sum[MOD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      acc     <= '0;
      m_frame <= '0;
      tap_sel <= '0;
    end else begin
      phase <= phase + MOD_W'(1);
      if (frame_last) begin
        acc     <= '0;
        m_frame <= m_next;
        tap_sel <= TAP_W'(fll_tap_clamp(5'(tap_raw), 5'(LIM)));
      end else begin
        acc <= sum[MOD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fll_postdiv.sv
module fll_postdiv #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              range_ext,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_out
);
  localparam int STAGES = (1 << CODE_W) - 1;
  logic [STAGES-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + STAGES'(1);
  end

  always_comb begin
    clk_out = clk;
    if (!range_ext && div_code != '0) clk_out = div_cnt[div_code - CODE_W'(1)];
  end
endmodule

// File: rtl/fll_core.sv
module fll_core #(
  parameter int INTEG_W   = 10,
  parameter int MOD_W     = 5,
  parameter int MULT_W    = 7,
  parameter int CODE_W    = 2,
  parameter int TAP_LIMIT = 28,
  parameter int SYNC_STG  = 2
) (
  input  logic               dco_clk,
  input  logic               rst_n,
  input  logic               ref_clk,
  input  logic [MULT_W-1:0]  mult_n,
  input  logic               range_ext,
  input  logic [CODE_W-1:0]  div_code,
  input  logic               loop_hold,
  input  logic               integ_wr,
  input  logic [INTEG_W-1:0] integ_wdata,
  output logic [INTEG_W-MOD_W-1:0] tap_sel,
  output logic               tap_up,
  output logic               clk_out,
  output logic [INTEG_W-1:0] integ_q
);
  logic             ref_evt;
  logic             step_up;
  logic             step_dn;
  logic             frame_last;
  logic [MOD_W-1:0] m_frame;

  fll_ref_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(dco_clk), .rst_n(rst_n), .ref_in(ref_clk), .ref_evt(ref_evt)
  );

  fll_integrator #(.INTEG_W(INTEG_W), .MULT_W(MULT_W), .CODE_W(CODE_W)) u_integ (
    .clk(dco_clk), .rst_n(rst_n), .ref_evt(ref_evt), .mult_n(mult_n),
    .div_code(div_code), .hold(loop_hold), .wr(integ_wr), .wdata(integ_wdata),
    .integ(integ_q), .step_up(step_up), .step_dn(step_dn)
  );

  fll_modulator #(.INTEG_W(INTEG_W), .MOD_W(MOD_W), .TAP_LIMIT(TAP_LIMIT)) u_mod (
    .clk(dco_clk), .rst_n(rst_n), .integ(integ_q), .tap_sel(tap_sel),
    .tap_up(tap_up), .frame_last(frame_last), .m_frame(m_frame)
  );

  fll_postdiv #(.CODE_W(CODE_W)) u_div (
    .clk(dco_clk), .rst_n(rst_n), .range_ext(range_ext),
    .div_code(div_code), .clk_out(clk_out)
  );
endmodule

// File: rtl/fll_core_chk.sv
module fll_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_evt,
  input logic       hold,
  input logic       wr,
  input logic [9:0] wdata,
  input logic [9:0] integ,
  input logic [4:0] tap_sel,
  input logic       tap_up,
  input logic       frame_last,
  input logic [4:0] m_frame
);
  logic [5:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          up_cnt <= '0;
    else if (frame_last) up_cnt <= '0;
    else if (tap_up)     up_cnt <= up_cnt + 6'd1;
  end

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> (integ == $past(integ) || integ == $past(integ) + 10'd1 ||
                    integ == $past(integ) - 10'd1));

  assert_step_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && integ != $past(integ)) |-> $past(ref_evt));

  assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && $past(integ) == 10'h3FF) |-> integ != 10'h000);

  assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && $past(integ) == 10'h000) |-> integ != 10'h3FF);

  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && !$past(wr)) |-> integ == $past(integ));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr) |-> integ == $past(wdata));

  assert_tap_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel <= 5'd28);

  assert_frame_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> (up_cnt + {5'd0, tap_up}) == {1'b0, m_frame});

  assert_top_tap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel == 5'd28 |-> !tap_up);
endmodule

bind fll_core fll_core_chk u_chk (
  .clk(dco_clk), .rst_n(rst_n), .ref_evt(ref_evt), .hold(loop_hold),
  .wr(integ_wr), .wdata(integ_wdata), .integ(integ_q), .tap_sel(tap_sel),
  .tap_up(tap_up), .frame_last(frame_last), .m_frame(m_frame)
);

// File: tb/fll_core_bench.sv
`timescale 1ns/1ps
module fll_core_bench;
  logic       dco_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [6:0] mult_n = 7'd31;
  logic       range_ext = 1'b0;
  logic [1:0] div_code = 2'd1;
  logic       loop_hold = 1'b1;
  logic       integ_wr = 1'b0;
  logic [9:0] integ_wdata = '0;
  logic [4:0] tap_sel;
  logic       tap_up;
  logic       clk_out;
  logic [9:0] integ_q;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  bit done = 0;

  always #2.5 dco_clk = ~dco_clk;
  always @(posedge clk_out) edges++;

  fll_core u_fll_core (
    .dco_clk(dco_clk), .rst_n(rst_n), .ref_clk(ref_clk), .mult_n(mult_n),
    .range_ext(range_ext), .div_code(div_code), .loop_hold(loop_hold),
    .integ_wr(integ_wr), .integ_wdata(integ_wdata), .tap_sel(tap_sel),
    .tap_up(tap_up), .clk_out(clk_out), .integ_q(integ_q)
  );

  // wdata[20:11], expected tap[10:6], expected tap+1 count per 32 cycles [5:0]
  localparam logic [20:0] VEC [8] = '{
    {10'd0,             5'd0,  6'd0},
    {5'd5,  5'd13,      5'd5,  6'd13},
    {5'd3,  5'd16,      5'd3,  6'd16},
    {5'd12, 5'd1,       5'd12, 6'd1},
    {5'd27, 5'd31,      5'd27, 6'd31},
    {5'd28, 5'd7,       5'd28, 6'd0},
    {5'd31, 5'd31,      5'd28, 6'd0},
    {5'd0,  5'd31,      5'd0,  6'd31}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge dco_clk);
    integ_wr = 1'b1; integ_wdata = v;
    @(negedge dco_clk);
    integ_wr = 1'b0;
  endtask

  task automatic ref_cycle(input int p);
    @(negedge dco_clk);
    ref_clk = 1'b1;
    repeat (p / 2 - 1) @(negedge dco_clk);
    @(negedge dco_clk);
    ref_clk = 1'b0;
    repeat (p - p / 2 - 1) @(negedge dco_clk);
  endtask

  // Runs k reference periods of p cycles after one warm-up period; returns change.
  task automatic run_loop(input int p, input int k, output int delta);
    int a;
    ref_cycle(p);
    a = integ_q;
    for (int i = 0; i < k; i++) ref_cycle(p);
    delta = int'(integ_q) - a;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int d;
    int cnt;
    int adj;
    bit prev;
    repeat (4) @(negedge dco_clk);
    // R11 reset state
    chk(integ_q == 0, "R11 integ", integ_q, 0);
    chk(tap_sel == 0, "R11 tap", tap_sel, 0);
    chk(tap_up == 0, "R11 tap_up", tap_up, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge dco_clk);
    chk(integ_q == 0, "R11 integ after release", integ_q, 0);

    // R6 R7 R8 R9 table walk with loop frozen
    foreach (VEC[v]) begin
      load(VEC[v][20:11]);
      repeat (70) @(negedge dco_clk);
      chk(tap_sel == VEC[v][10:6], "R6 tap_sel", tap_sel, VEC[v][10:6]);
      cnt = 0; adj = 0; prev = 1'b0;
      for (int c = 0; c < 32; c++) begin
        if (tap_up) cnt++;
        if (tap_up && prev) adj++;
        prev = tap_up;
        @(negedge dco_clk);
      end
      if (VEC[v][10:6] == 5'd28) chk(cnt == 0, "R9 no tap+1 at top", cnt, 0);
      else chk(cnt == VEC[v][5:0], "R7 tap+1 count", cnt, VEC[v][5:0]);
      if (VEC[v][5:0] <= 6'd16) chk(adj == 0, "R8 spread", adj, 0);
    end

    // R5 load while held, and while running
    load(10'd300);
    chk(integ_q == 300, "R5 load held", integ_q, 300);
    loop_hold = 1'b0;
    load(10'd500);
    chk(integ_q == 500, "R5 load running", integ_q, 500);

    // R1 R2 target 64 (N=31, D=2)
    run_loop(40, 5, d);  chk(d == 5,  "R1 short period up", d, 5);
    run_loop(90, 5, d);  chk(d == -5, "R1 long period down", d, -5);
    run_loop(64, 4, d);  chk(d == -4, "R1 equal count down", d, -4);
    run_loop(63, 4, d);  chk(d == 4,  "R1 one short up", d, 4);
    // R1 target 10 (N=9, D=1)
    mult_n = 7'd9; div_code = 2'd0;
    run_loop(8, 6, d);   chk(d == 6,  "R1 N9 D1 up", d, 6);
    run_loop(12, 6, d);  chk(d == -6, "R1 N9 D1 down", d, -6);
    // R1 target 80 (N=9, D=8)
    div_code = 2'd3;
    run_loop(76, 3, d);  chk(d == 3,  "R1 N9 D8 up", d, 3);
    mult_n = 7'd31; div_code = 2'd1;

    // R4 hold
    loop_hold = 1'b1;
    run_loop(20, 4, d);  chk(d == 0, "R4 hold", d, 0);
    loop_hold = 1'b0;

    // R3 saturation
    load(10'h3FF);
    run_loop(20, 3, d);
    chk(integ_q == 10'h3FF, "R3 top", integ_q, 1023);
    load(10'h000);
    run_loop(100, 3, d);
    chk(integ_q == 10'h000, "R3 bottom", integ_q, 0);

    // R10 post-divider and range extension
    for (int c = 0; c < 4; c++) begin
      div_code = 2'(c); range_ext = 1'b0;
      repeat (4) @(negedge dco_clk);
      d = edges;
      repeat (64) @(negedge dco_clk);
      chk(edges - d == (64 >> c), "R10 divided rate", edges - d, 64 >> c);
    end
    div_code = 2'd3; range_ext = 1'b1;
    repeat (4) @(negedge dco_clk);
    d = edges;
    repeat (64) @(negedge dco_clk);
    chk(edges - d == 64, "R10 range extension", edges - d, 64);

    done = 1;
    summary();
  end
endmodule